// File: doc/BRIEF.md
# TDMA Crossbar Cell Scheduler

This block is an N-by-N cell switch. Every cell has the same width. Each input port holds a small FIFO for each flow it carries. A cell that arrives on an input lane is written into the FIFO chosen by its flow index.

A free-running divider marks a cell-time boundary every `CELL_CYCLES` clocks. At each boundary every output consults its own entry in a programmed table of `SLOTS` slots. All outputs use the current slot number together. An entry names one input and one flow. If that FIFO holds a cell, its head is moved to the output lane. If the FIFO is empty, the output stays idle for that slot. No other queue ever takes an unused slot.

Writes to the table are screened when they happen. A write that would let one input feed two outputs in the same slot is refused, and so is a write carrying an out-of-range field. This keeps every slot a matching of inputs to outputs.

Top module: `tdmaXbar`

## Requirements
- R1: After reset, every outValid bit is low, dropCnt is zero and cfgErr is low. The divider restarts so that the first cell-time boundary is the CELL_CYCLES-th rising edge after reset is released, and that boundary serves slot 0.
- R2: Cells of one (input, flow) pair leave in the order they arrived, and each such FIFO holds up to DEPTH cells.
- R3: Output lanes change only on boundary edges. An outValid bit is high for exactly one clock after a boundary edge and low on every other clock.
- R4: Successive boundaries serve slots 0, 1, …, SLOTS-1, and then slot 0 again.
- R5: At a boundary that serves slot s, output o forwards the head cell of FIFO (table[o][s].input, table[o][s].flow), provided the entry is enabled and the FIFO is non-empty. Otherwise output o is idle and no other queue is served. Input lane i carries bits [i*CELL_W +: CELL_W] of inData, and its flow index is inFlow[i*FW +: FW].
- R6: A write (cfgWe high) is rejected in three cases: it is enabling and another output already has an enabled entry at the same slot with the same input; cfgSlot ≥ SLOTS; or any index is out of range. A rejected write raises cfgErr for the single clock after the write and leaves the table unchanged. An accepted write keeps cfgErr low.
- R7: A cell that arrives for a FIFO that already holds DEPTH cells is discarded, and dropCnt increases by one. Fullness is judged on the count before the edge, so a forward at that same edge does not make room.
- R8: One input may send several of its flows to the same output in different slots. Each slot takes cells only from the flow its entry names.
- R9: A write with cfgValid low disables the entry, so its slot goes idle. It also frees that input for other outputs in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | NPORTS | Per-input cell present this clock |
| inFlow | input | NPORTS*FW | Per-input flow index |
| inData | input | NPORTS*CELL_W | Per-input cell payload |
| cfgWe | input | 1 | Table write strobe |
| cfgOut | input | IW | Output whose entry is written |
| cfgSlot | input | SW | Slot whose entry is written |
| cfgIn | input | IW | Input named by the entry |
| cfgFlow | input | FW | Flow named by the entry |
| cfgValid | input | 1 | 1 enables the entry, 0 disables it |
| cfgErr | output | 1 | Write was rejected (one-clock pulse) |
| outValid | output | NPORTS | Per-output cell forwarded |
| outData | output | NPORTS*CELL_W | Per-output cell payload |
| dropCnt | output | DROP_W | Total cells discarded on full FIFOs |

## Verification
Each result has a fixed latency:
- A forwarded cell appears in the clock that follows a boundary edge. The boundaries are the CELL_CYCLES-th rising edge after reset and every CELL_CYCLES-th edge after that.
- cfgErr appears in the clock after the write.
- A dropped cell shows in dropCnt in the clock after it arrived.

The bench numbers the rising edges from reset release. It samples every output at the falling edge that follows each rising edge. For each edge it applies what that edge saw to its own queue and table model, in this order: forward eligibility from the pre-edge queue sizes, then arrivals, then forwards under the old table, then the table write. That order makes the expected value for every sampled clock exact, including a cell that arrives in the same edge as a forward.

// File: rtl/xbarPkg.sv
package xbarPkg;
  // strobes sent from the control to the datapath once per clock
  typedef struct packed {
    logic tick;      // cell-time boundary at this edge
    logic lastSlot;  // boundary serves the final slot of the frame
  } xbarStrobeT;
endpackage

// File: rtl/xbarCtrl.sv
module xbarCtrl
  import xbarPkg::*;
#(
  parameter int NPORTS      = 4,
  parameter int NFLOWS      = 2,
  parameter int SLOTS       = 5,
  parameter int CELL_CYCLES = 4,
  localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int FW = (NFLOWS > 1) ? $clog2(NFLOWS) : 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CW = (CELL_CYCLES > 1) ? $clog2(CELL_CYCLES) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWe,
  input  logic [IW-1:0]  cfgOut,
  input  logic [SW-1:0]  cfgSlot,
  input  logic [IW-1:0]  cfgIn,
  input  logic [FW-1:0]  cfgFlow,
  input  logic           cfgValid,
  output logic           cfgErr,
  output xbarStrobeT     strobe,
  output logic           selValid [NPORTS],
  output logic [IW-1:0]  selIn    [NPORTS],
  output logic [FW-1:0]  selFlow  [NPORTS]
);
  logic [CW-1:0] cycCnt;
  logic [SW-1:0] slotIdx;
  logic          tick;
  logic          clash;

  logic          entValid [NPORTS][SLOTS];
  logic [IW-1:0] entIn    [NPORTS][SLOTS];
  logic [FW-1:0] entFlow  [NPORTS][SLOTS];

  assign tick = (cycCnt == CW'(CELL_CYCLES - 1));

  always_comb begin
    strobe.tick     = tick;
    strobe.lastSlot = tick && (int'(slotIdx) == SLOTS - 1);
  end

  // cell-time divider and slot counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt  <= '0;
      slotIdx <= '0;
    end else if (tick) begin
      cycCnt  <= '0;
      slotIdx <= strobe.lastSlot ? '0 : slotIdx + 1'b1;
    end else begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  // write-time screening keeps each slot a matching
  always_comb begin
    clash = 1'b0;
    if (int'(cfgOut) >= NPORTS || int'(cfgSlot) >= SLOTS ||
        int'(cfgIn) >= NPORTS || int'(cfgFlow) >= NFLOWS) begin
      clash = 1'b1;
    end else if (cfgValid) begin
      for (int o = 0; o < NPORTS; o++) begin
        if (o != int'(cfgOut) && entValid[o][cfgSlot] &&
            entIn[o][cfgSlot] == cfgIn)
          clash = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgErr <= 1'b0;
      for (int o = 0; o < NPORTS; o++) begin
        for (int s = 0; s < SLOTS; s++) begin
          entValid[o][s] <= 1'b0;
          entIn[o][s]    <= '0;
          entFlow[o][s]  <= '0;
        end
      end
    end else begin
      cfgErr <= cfgWe && clash;
      if (cfgWe && !clash) begin
        entValid[cfgOut][cfgSlot] <= cfgValid;
        entIn[cfgOut][cfgSlot]    <= cfgIn;
        entFlow[cfgOut][cfgSlot]  <= cfgFlow;
      end
    end
  end

  always_comb begin
    for (int o = 0; o < NPORTS; o++) begin
      selValid[o] = entValid[o][slotIdx];
      selIn[o]    = entIn[o][slotIdx];
      selFlow[o]  = entFlow[o][slotIdx];
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(slotIdx) < SLOTS); // R4
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && int'(slotIdx) == SLOTS - 1) |=> (slotIdx == '0)); // R4
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(slotIdx)); // R3

  always @(posedge clk) begin
    if (rstN) begin
      for (int s = 0; s < SLOTS; s++)
        for (int a = 0; a < NPORTS; a++)
          for (int b = a + 1; b < NPORTS; b++)
            AST_MATCHING: assert (!(entValid[a][s] && entValid[b][s] &&
                                    entIn[a][s] == entIn[b][s])); // R6
    end
  end
endmodule

// File: rtl/xbarData.sv
module xbarData
  import xbarPkg::*;
#(
  parameter int NPORTS      = 4,
  parameter int NFLOWS      = 2,
  parameter int DEPTH       = 4,
  parameter int CELL_W      = 16,
  parameter int DROP_W      = 16,
  parameter int CELL_CYCLES = 4,
  localparam int IW   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int FW   = (NFLOWS > 1) ? $clog2(NFLOWS) : 1,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int DNW  = $clog2(NPORTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  xbarStrobeT        strobe,
  input  logic              selValid [NPORTS],
  input  logic [IW-1:0]     selIn    [NPORTS],
  input  logic [FW-1:0]     selFlow  [NPORTS],
  input  logic              inValid  [NPORTS],
  input  logic [FW-1:0]     inFlow   [NPORTS],
  input  logic [CELL_W-1:0] inData   [NPORTS],
  output logic              outValid [NPORTS],
  output logic [CELL_W-1:0] outData  [NPORTS],
  output logic [DROP_W-1:0] dropCnt
);
  logic [CELL_W-1:0] mem   [NPORTS][NFLOWS][DEPTH];
  logic [PW-1:0]     wrPtr [NPORTS][NFLOWS];
  logic [PW-1:0]     rdPtr [NPORTS][NFLOWS];
  logic [CNTW-1:0]   cnt   [NPORTS][NFLOWS];
  logic              pushReq [NPORTS][NFLOWS];
  logic              popReq  [NPORTS][NFLOWS];
  logic              serve   [NPORTS];
  logic [DNW-1:0]    dropNum;
  logic              taken;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  // arrivals: one cell per input, dropped when its FIFO is full
  always_comb begin
    dropNum = '0;
    taken   = 1'b0;
    for (int i = 0; i < NPORTS; i++) begin
      taken = 1'b0;
      for (int f = 0; f < NFLOWS; f++) begin
        pushReq[i][f] = inValid[i] && int'(inFlow[i]) == f &&
                        cnt[i][f] != CNTW'(DEPTH);
        taken = taken | pushReq[i][f];
      end
      if (inValid[i] && !taken) dropNum = dropNum + DNW'(1);
    end
  end

  // departures: each output pulls its scheduled queue at a boundary
  always_comb begin
    for (int i = 0; i < NPORTS; i++)
      for (int f = 0; f < NFLOWS; f++)
        popReq[i][f] = 1'b0;
    for (int o = 0; o < NPORTS; o++) begin
      serve[o] = strobe.tick && selValid[o] &&
                 cnt[selIn[o]][selFlow[o]] != '0;
      if (serve[o]) popReq[selIn[o]][selFlow[o]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPORTS; i++)
      for (int f = 0; f < NFLOWS; f++)
        if (pushReq[i][f]) mem[i][f][wrPtr[i][f]] <= inData[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NPORTS; i++) begin
        for (int f = 0; f < NFLOWS; f++) begin
          wrPtr[i][f] <= '0;
          rdPtr[i][f] <= '0;
          cnt[i][f]   <= '0;
        end
      end
    end else begin
      for (int i = 0; i < NPORTS; i++) begin
        for (int f = 0; f < NFLOWS; f++) begin
          if (pushReq[i][f]) wrPtr[i][f] <= nextPtr(wrPtr[i][f]);
          if (popReq[i][f])  rdPtr[i][f] <= nextPtr(rdPtr[i][f]);
          cnt[i][f] <= cnt[i][f] + CNTW'(pushReq[i][f]) - CNTW'(popReq[i][f]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropCnt <= '0;
      for (int o = 0; o < NPORTS; o++) begin
        outValid[o] <= 1'b0;
        outData[o]  <= '0;
      end
    end else begin
      dropCnt <= dropCnt + DROP_W'(dropNum);
      for (int o = 0; o < NPORTS; o++) begin
        outValid[o] <= serve[o];
        if (serve[o])
          outData[o] <= mem[selIn[o]][selFlow[o]][rdPtr[selIn[o]][selFlow[o]]];
      end
    end
  end

  for (genvar gi = 0; gi < NPORTS; gi++) begin : g_qchk
    for (genvar gf = 0; gf < NFLOWS; gf++) begin : g_fchk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
        int'(cnt[gi][gf]) <= DEPTH); // R7
    end
  end

  if (CELL_CYCLES > 1) begin : g_pulse
    for (genvar go = 0; go < NPORTS; go++) begin : g_ochk
      AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
        outValid[go] |=> !outValid[go]); // R3
    end
  end

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    DROP_W'(dropCnt - $past(dropCnt)) <= DROP_W'(NPORTS)); // R7
endmodule

// File: rtl/tdmaXbar.sv
module tdmaXbar
  import xbarPkg::*;
#(
  parameter int NPORTS      = 4,
  parameter int NFLOWS      = 2,
  parameter int SLOTS       = 5,
  parameter int CELL_CYCLES = 4,
  parameter int DEPTH       = 4,
  parameter int CELL_W      = 16,
  parameter int DROP_W      = 16,
  localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int FW = (NFLOWS > 1) ? $clog2(NFLOWS) : 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NPORTS-1:0]        inValid,
  input  logic [NPORTS*FW-1:0]     inFlow,
  input  logic [NPORTS*CELL_W-1:0] inData,
  input  logic                     cfgWe,
  input  logic [IW-1:0]            cfgOut,
  input  logic [SW-1:0]            cfgSlot,
  input  logic [IW-1:0]            cfgIn,
  input  logic [FW-1:0]            cfgFlow,
  input  logic                     cfgValid,
  output logic                     cfgErr,
  output logic [NPORTS-1:0]        outValid,
  output logic [NPORTS*CELL_W-1:0] outData,
  output logic [DROP_W-1:0]        dropCnt
);
  xbarStrobeT        strobe;
  logic              selValid  [NPORTS];
  logic [IW-1:0]     selIn     [NPORTS];
  logic [FW-1:0]     selFlow   [NPORTS];
  logic              inValidA  [NPORTS];
  logic [FW-1:0]     inFlowA   [NPORTS];
  logic [CELL_W-1:0] inDataA   [NPORTS];
  logic              outValidA [NPORTS];
  logic [CELL_W-1:0] outDataA  [NPORTS];

  for (genvar g = 0; g < NPORTS; g++) begin : g_lane
    assign inValidA[g]                = inValid[g];
    assign inFlowA[g]                 = inFlow[g*FW +: FW];
    assign inDataA[g]                 = inData[g*CELL_W +: CELL_W];
    assign outValid[g]                = outValidA[g];
    assign outData[g*CELL_W +: CELL_W] = outDataA[g];
  end

  xbarCtrl #(
    .NPORTS(NPORTS), .NFLOWS(NFLOWS), .SLOTS(SLOTS), .CELL_CYCLES(CELL_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgOut(cfgOut), .cfgSlot(cfgSlot),
    .cfgIn(cfgIn), .cfgFlow(cfgFlow), .cfgValid(cfgValid), .cfgErr(cfgErr),
    .strobe(strobe), .selValid(selValid), .selIn(selIn), .selFlow(selFlow)
  );

  xbarData #(
    .NPORTS(NPORTS), .NFLOWS(NFLOWS), .DEPTH(DEPTH), .CELL_W(CELL_W),
    .DROP_W(DROP_W), .CELL_CYCLES(CELL_CYCLES)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selValid(selValid),
    .selIn(selIn), .selFlow(selFlow), .inValid(inValidA), .inFlow(inFlowA),
    .inData(inDataA), .outValid(outValidA), .outData(outDataA),
    .dropCnt(dropCnt)
  );
endmodule

// File: tb/tdmaXbar_bench.sv
module tdmaXbar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int F = 2;
  localparam int M = 5;
  localparam int C = 4;
  localparam int D = 4;
  localparam int W = 16;
  localparam int FW = 1;
  localparam int IW = 2;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]    inValid = '0;
  logic [N*FW-1:0] inFlow = '0;
  logic [N*W-1:0]  inData = '0;
  logic cfgWe = 1'b0;
  logic [IW-1:0] cfgOut = '0;
  logic [SW-1:0] cfgSlot = '0;
  logic [IW-1:0] cfgIn = '0;
  logic [FW-1:0] cfgFlow = '0;
  logic cfgValid = 1'b0;
  logic cfgErr;
  logic [N-1:0]   outValid;
  logic [N*W-1:0] outData;
  logic [15:0]    dropCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdmaXbar u_tdmaXbar (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFlow(inFlow), .inData(inData),
    .cfgWe(cfgWe), .cfgOut(cfgOut), .cfgSlot(cfgSlot), .cfgIn(cfgIn),
    .cfgFlow(cfgFlow), .cfgValid(cfgValid), .cfgErr(cfgErr),
    .outValid(outValid), .outData(outData), .dropCnt(dropCnt)
  );

  int nChk = 0;
  int nFail = 0;
  int e = 0;
  int expDrop = 0;
  bit done = 1'b0;

  // scoreboard state: expected FIFO contents and expected table
  logic [W-1:0] mq [N][F][$];
  bit tV [N][M];
  int tI [N][M];
  int tF [N][M];

  // what the last rising edge saw on the inputs
  bit sV [N];
  int sF [N];
  logic [W-1:0] sD [N];
  bit sWe, sCv;
  int sOut, sSlot, sIn, sFl;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  initial begin
    for (int o = 0; o < N; o++)
      for (int s = 0; s < M; s++) begin
        tV[o][s] = 1'b0; tI[o][s] = 0; tF[o][s] = 0;
      end
  end

  always @(posedge clk) begin
    if (rstN) begin
      e++;
      for (int i = 0; i < N; i++) begin
        sV[i] = inValid[i];
        sF[i] = int'(inFlow[i*FW +: FW]);
        sD[i] = inData[i*W +: W];
      end
      sWe = cfgWe; sCv = cfgValid;
      sOut = int'(cfgOut); sSlot = int'(cfgSlot);
      sIn = int'(cfgIn); sFl = int'(cfgFlow);
    end
  end

  // monitor: replay the edge into the model, then compare
  always @(negedge clk) begin
    int pre [N][F];
    bit tickNow, ev, pred;
    int slot;
    logic [W-1:0] ed;
    if (rstN && e > 0) begin
      tickNow = (e % C) == 0;
      slot = tickNow ? ((e / C) - 1) % M : 0;
      for (int i = 0; i < N; i++)
        for (int f = 0; f < F; f++)
          pre[i][f] = mq[i][f].size();
      for (int i = 0; i < N; i++)
        if (sV[i]) begin
          if (mq[i][sF[i]].size() >= D) expDrop++;
          else mq[i][sF[i]].push_back(sD[i]);
        end
      for (int o = 0; o < N; o++) begin
        ev = 1'b0; ed = '0;
        if (tickNow && tV[o][slot] && pre[tI[o][slot]][tF[o][slot]] > 0) begin
          ev = 1'b1;
          ed = mq[tI[o][slot]][tF[o][slot]].pop_front();
        end
        chk(outValid[o] == ev, tickNow ? "R4 R5 outValid at boundary" : "R3 outValid between boundaries",
            outValid[o], ev);
        if (ev) chk(outData[o*W +: W] == ed, "R2 R8 forwarded cell", outData[o*W +: W], ed);
      end
      if (sWe) begin
        pred = (sSlot >= M) || (sOut >= N) || (sIn >= N) || (sFl >= F);
        if (!pred && sCv)
          for (int o = 0; o < N; o++)
            if (o != sOut && tV[o][sSlot] && tI[o][sSlot] == sIn) pred = 1'b1;
        chk(cfgErr == pred, "R6 write screening", cfgErr, pred);
        if (!pred) begin
          tV[sOut][sSlot] = sCv; tI[sOut][sSlot] = sIn; tF[sOut][sSlot] = sFl;
        end
      end else begin
        chk(cfgErr == 1'b0, "R6 no error without write", cfgErr, 0);
      end
      chk(dropCnt == 16'(expDrop), "R7 drop count", dropCnt, expDrop);
    end
  end

  task automatic cfgWrite(input int o, input int s, input int i, input int f, input bit v);
    cfgWe = 1'b1; cfgOut = IW'(o); cfgSlot = SW'(s); cfgIn = IW'(i);
    cfgFlow = FW'(f); cfgValid = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic putCell(input int i, input int f, input logic [W-1:0] d);
    inValid[i] = 1'b1; inFlow[i*FW +: FW] = FW'(f); inData[i*W +: W] = d;
    @(negedge clk);
    inValid[i] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // first edge: table write for out1 slot0 plus a cell for input 2 flow 1
    cfgWe = 1'b1; cfgOut = 2'd1; cfgSlot = 3'd0; cfgIn = 2'd2; cfgFlow = 1'b1; cfgValid = 1'b1;
    inValid[2] = 1'b1; inFlow[2] = 1'b1; inData[2*W +: W] = 16'h2100;
    @(negedge clk);
    cfgWe = 1'b0; inValid[2] = 1'b0;
    chk(outValid == '0, "R1 outValid after reset", outValid, 0);
    chk(dropCnt == '0, "R1 dropCnt after reset", dropCnt, 0);
    chk(cfgErr == 1'b0, "R1 cfgErr after reset", cfgErr, 0);
    wait (e == C);
    @(negedge clk);
    chk(outValid[1] == 1'b1, "R1 first boundary serves slot 0", outValid[1], 1);
    chk(outData[1*W +: W] == 16'h2100, "R1 first cell", outData[1*W +: W], 16'h2100);

    cfgWrite(0, 0, 1, 0, 1'b1);
    cfgWrite(0, 2, 1, 1, 1'b1);   // R8: same input, other flow, same output
    cfgWrite(2, 1, 1, 1, 1'b1);
    cfgWrite(3, 4, 0, 0, 1'b1);
    cfgWrite(3, 0, 1, 0, 1'b1);   // R6: input 1 already feeds out0 in slot 0
    cfgWrite(2, 6, 0, 0, 1'b1);   // R6: slot out of range

    putCell(1, 0, 16'h1001); putCell(1, 0, 16'h1002);
    putCell(1, 1, 16'h1101); putCell(1, 1, 16'h1102); putCell(1, 1, 16'h1103);
    putCell(0, 0, 16'h0001); putCell(0, 0, 16'h0002);
    putCell(2, 1, 16'h2101);
    idle(3 * M * C);

    for (int k = 1; k <= 6; k++) putCell(3, 0, 16'h3000 + 16'(k)); // R7: two dropped
    idle(3);
    chk(dropCnt == 16'd2, "R7 two cells dropped on full FIFO", dropCnt, 2);
    cfgWrite(3, 3, 3, 0, 1'b1);
    idle(5 * M * C);

    cfgWrite(0, 0, 0, 0, 1'b0);   // R9: disable entry
    putCell(1, 0, 16'h1004);
    idle(2 * M * C);
    cfgWrite(2, 0, 1, 0, 1'b1);   // R9: input 1 now free in slot 0
    idle(2 * M * C);
    // back-to-back arrivals across a boundary
    putCell(1, 0, 16'h1005); putCell(1, 0, 16'h1006); putCell(1, 0, 16'h1007);
    idle(4 * M * C);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", e, 0);
      summary();
      $finish;
    end
  end
endmodule